// File: doc/BRIEF.md
# Time-Slot Serial DAC Packet Sequencer

This block turns a host request into a 32-bit serial packet for an external DAC chain. A request carries a signed setpoint, a channel number and a flag that picks between the main DAC format and the trim DAC format. The block builds the packet word and then runs a six-slot sequence. Slot 1 stages the word. Slots 2 to 5 each shift one byte onto a shared data line while one of three chip-select strobes is driven. Slot 0 is the trap slot. After slot 5 the sequence wraps to slot 0, where it stops until the next request arrives.

The serial clock and the strobes are enabled only while the four data slots run. The wrap to slot 0 removes that enable again. Slots 4 and 5 carry filler bytes on the third strobe, which goes to an unused channel, so the serial clock keeps running cleanly after the last real data bit. A feedback byte drops to 0x00 when slot 5 finishes and returns to 0xFF when slot 0 runs again. Logic that watches this byte can therefore see each pass end. Each main channel has its own polarity bit, which holds the sign of its setpoint. That bit is updated before the first serial clock of the transfer.

Top module: `tsdac_seq`

## Requirements
- R1: After reset, busy_o, done_o, sclk_o, sdata_o, cs_o and pol_o are all 0, and fb_top_o is 0xFF.
- R2: When req_trim_i is 0, the packet bytes in transmission order are {chan[0], 1, 0, M[12:8]}, M[7:0], 0x0F, 0x00. Here M is the 13-bit setpoint magnitude.
- R3: For a main request, M is the absolute value of the signed setpoint. Any value above 0x1FFF, including the most negative input, is sent as 0x1FFF.
- R4: A main request writes its sign into pol_o[chan[1:0]]: 1 for a negative setpoint, 0 otherwise. The new value is visible before the first serial clock of that packet. Trim requests leave pol_o unchanged.
- R5: Strobes are active high, and at most one is active at a time. For a main request, bytes 0 and 1 use cs_o[0] when chan[1] is 0 and cs_o[1] when chan[1] is 1. Bytes 2 and 3 always use cs_o[2].
- R6: When req_trim_i is 1, the packet is {0000, chan[3:0]}, setpt[7:0], 0x00, 0x00, with all four bytes on cs_o[2].
- R7: Each byte is sent MSB first, one bit per sclk_o pulse, with 8 pulses per byte and 32 per packet. sdata_o is valid while sclk_o is high. sclk_o, sdata_o and cs_o stay 0 outside the four data slots.
- R8: fb_top_o becomes 0x00 when slot 5 completes. It returns to 0xFF when slot 0 completes and the sequencer traps. It holds no other value.
- R9: busy_o goes high in the cycle after a request is accepted. done_o pulses for exactly one cycle, 96 cycles after acceptance (six slots of 16 cycles each), with fb_top_o equal to 0xFF.
- R10: A request is started only while the sequencer is trapped at slot 0. A request made during a pass is held in one buffer, keeps busy_o high, and starts right after the trap. A further request made while that buffer is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_trim_i | input | 1 | 1 selects the trim packet format |
| req_chan_i | input | 4 | Channel number (main uses bits 1:0, trim uses all 4) |
| req_setpt_i | input | SP_W | Signed setpoint (trim uses bits 7:0) |
| busy_o | output | 1 | Pass running or request held |
| done_o | output | 1 | One-cycle pulse when the sequencer traps at slot 0 |
| pol_o | output | 4 | Per-channel polarity bits |
| sclk_o | output | 1 | Gated serial clock |
| sdata_o | output | 1 | Serial data |
| cs_o | output | 3 | Chip-select strobes |
| fb_top_o | output | 8 | Feedback byte used to detect the end of a pass |

## Verification
The assertions assume that req_valid_i is a single-cycle pulse sampled on the clock, and that the request fields are valid in the same cycle. They also assume reset is held for a few cycles, so the internal reset synchronizer clears before checking starts. The stimulus always drives a request for exactly one cycle, from the falling edge. New requests are issued only when the block is idle, except in the deliberate hold-and-drop sequence. In that sequence, the one held request is issued mid-pass and the dropped one is issued while the buffer is still full.

// File: rtl/tsdac_pkg.sv
package tsdac_pkg;
  localparam int BYTE_BITS = 8;
  localparam int PKT_BYTES = 4;
  localparam int WORD_W    = BYTE_BITS * PKT_BYTES;
  localparam int MAG_W     = 13;
  localparam int CHAN_W    = 4;
  localparam int POL_N     = 4;
  localparam int STRB_N    = 3;
  localparam int SLOT_CYC  = 2 * BYTE_BITS;
  localparam int PH_W      = $clog2(SLOT_CYC);

  typedef enum logic [2:0] {
    SLOT_TRAP  = 3'd0,
    SLOT_FETCH = 3'd1,
    SLOT_HI    = 3'd2,
    SLOT_LO    = 3'd3,
    SLOT_PAD0  = 3'd4,
    SLOT_PAD1  = 3'd5
  } slot_t;
endpackage

// File: rtl/tsdac_fmt.sv
module tsdac_fmt
  import tsdac_pkg::*;
#(
  parameter int SP_W = 16
) (
  input  logic                     trim_i,
  input  logic [CHAN_W-1:0]        chan_i,
  input  logic [SP_W-1:0]          setpt_i,
  output logic [WORD_W-1:0]        word_o,
  output logic                     neg_o
);
  localparam logic [SP_W:0] MAG_MAX = (SP_W+1)'((1 << MAG_W) - 1);

  logic [SP_W:0]      ext;
  logic [SP_W:0]      mag_full;
  logic [MAG_W-1:0]   mag;

  always_comb begin
    ext      = {setpt_i[SP_W-1], setpt_i};
    mag_full = setpt_i[SP_W-1] ? (~ext + 1'b1) : ext;
    mag      = (mag_full > MAG_MAX) ? MAG_MAX[MAG_W-1:0] : mag_full[MAG_W-1:0];
    neg_o    = setpt_i[SP_W-1];
    if (trim_i) begin
      word_o = {4'h0, chan_i, setpt_i[7:0], 8'h00, 8'h00};
    end else begin
      word_o = {chan_i[0], 1'b1, 1'b0, mag[MAG_W-1:8], mag[7:0], 8'h0F, 8'h00};
    end
  end
endmodule

// File: rtl/tsdac_timer.sv
module tsdac_timer
  import tsdac_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  output logic            active_o,
  output slot_t           slot_o,
  output logic [PH_W-1:0] phase_o,
  output logic            pass_end_o,
  output logic            trap_hit_o
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYC - 1);

  logic            active_q, active_d;
  slot_t           slot_q, slot_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            slot_end;

  assign slot_end = active_q && (phase_q == PH_LAST);

  always_comb begin
    active_d = active_q;
    slot_d   = slot_q;
    phase_d  = phase_q;
    if (launch_i && !active_q) begin
      active_d = 1'b1;
      slot_d   = SLOT_FETCH;
      phase_d  = '0;
    end else if (active_q) begin
      if (slot_end) begin
        phase_d = '0;
        case (slot_q)
          SLOT_PAD1: slot_d   = SLOT_TRAP;
          SLOT_TRAP: active_d = 1'b0;
          default:   slot_d   = slot_t'(slot_q + 3'd1);
        endcase
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= SLOT_TRAP;
      phase_q  <= '0;
    end else begin
      active_q <= active_d;
      slot_q   <= slot_d;
      phase_q  <= phase_d;
    end
  end

  assign active_o   = active_q;
  assign slot_o     = slot_q;
  assign phase_o    = phase_q;
  assign pass_end_o = slot_end && (slot_q == SLOT_PAD1);
  assign trap_hit_o = slot_end && (slot_q == SLOT_TRAP);
endmodule

// File: rtl/tsdac_ser.sv
module tsdac_ser
  import tsdac_pkg::*;
(
  input  logic              active_i,
  input  slot_t             slot_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              trim_i,
  input  logic              cs_hi_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic [STRB_N-1:0] cs_o
);
  logic                 dslot;
  logic [BYTE_BITS-1:0] cur_byte;
  logic [2:0]           bit_idx;
  logic [1:0]           want;

  always_comb begin
    dslot    = 1'b0;
    cur_byte = '0;
    case (slot_i)
      SLOT_HI:   begin dslot = active_i; cur_byte = word_i[WORD_W-1 -: BYTE_BITS];   end
      SLOT_LO:   begin dslot = active_i; cur_byte = word_i[WORD_W-9 -: BYTE_BITS];   end
      SLOT_PAD0: begin dslot = active_i; cur_byte = word_i[WORD_W-17 -: BYTE_BITS];  end
      SLOT_PAD1: begin dslot = active_i; cur_byte = word_i[WORD_W-25 -: BYTE_BITS];  end
      default:   begin dslot = 1'b0;     cur_byte = '0;                              end
    endcase
    bit_idx = 3'd7 - phase_i[PH_W-1:1];
    if ((slot_i == SLOT_HI || slot_i == SLOT_LO) && !trim_i) begin
      want = {1'b0, cs_hi_i};
    end else begin
      want = 2'd2;
    end
  end

  assign sclk_o  = dslot && phase_i[0];
  assign sdata_o = dslot && cur_byte[bit_idx];

  for (genvar g = 0; g < STRB_N; g++) begin : g_strb
    assign cs_o[g] = dslot && (want == 2'(g));
  end
endmodule

// File: rtl/tsdac_seq.sv
module tsdac_seq
  import tsdac_pkg::*;
#(
  parameter int SP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_trim_i,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic [SP_W-1:0]   req_setpt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [POL_N-1:0]  pol_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic [STRB_N-1:0] cs_o,
  output logic [BYTE_BITS-1:0] fb_top_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // request hold buffer
  logic              pend_v_q, pend_v_d;
  logic              pend_trim_q, pend_trim_d;
  logic [CHAN_W-1:0] pend_chan_q, pend_chan_d;
  logic [SP_W-1:0]   pend_sp_q, pend_sp_d;

  logic              sel_trim;
  logic [CHAN_W-1:0] sel_chan;
  logic [SP_W-1:0]   sel_sp;
  logic [WORD_W-1:0] fmt_word;
  logic              fmt_neg;

  logic              active, pass_end, trap_hit, launch, capture;
  slot_t             slot;
  logic [PH_W-1:0]   phase;

  logic [WORD_W-1:0] word_q, word_d;
  logic              trim_q, trim_d;
  logic              cs_hi_q, cs_hi_d;
  logic [POL_N-1:0]  pol_q, pol_d;
  logic [BYTE_BITS-1:0] fb_q, fb_d;
  logic              done_q, done_d;

  assign sel_trim = pend_v_q ? pend_trim_q : req_trim_i;
  assign sel_chan = pend_v_q ? pend_chan_q : req_chan_i;
  assign sel_sp   = pend_v_q ? pend_sp_q   : req_setpt_i;
  assign launch   = !active && (pend_v_q || req_valid_i);
  assign capture  = active && req_valid_i && !pend_v_q;

  tsdac_fmt #(.SP_W(SP_W)) fmt_i (
    .trim_i  (sel_trim),
    .chan_i  (sel_chan),
    .setpt_i (sel_sp),
    .word_o  (fmt_word),
    .neg_o   (fmt_neg)
  );

  tsdac_timer timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .launch_i   (launch),
    .active_o   (active),
    .slot_o     (slot),
    .phase_o    (phase),
    .pass_end_o (pass_end),
    .trap_hit_o (trap_hit)
  );

  tsdac_ser ser_i (
    .active_i (active),
    .slot_i   (slot),
    .phase_i  (phase),
    .word_i   (word_q),
    .trim_i   (trim_q),
    .cs_hi_i  (cs_hi_q),
    .sclk_o   (sclk_o),
    .sdata_o  (sdata_o),
    .cs_o     (cs_o)
  );

  always_comb begin
    pend_v_d    = pend_v_q;
    pend_trim_d = pend_trim_q;
    pend_chan_d = pend_chan_q;
    pend_sp_d   = pend_sp_q;
    word_d      = word_q;
    trim_d      = trim_q;
    cs_hi_d     = cs_hi_q;
    pol_d       = pol_q;
    fb_d        = fb_q;
    done_d      = trap_hit;
    if (capture) begin
      pend_v_d    = 1'b1;
      pend_trim_d = req_trim_i;
      pend_chan_d = req_chan_i;
      pend_sp_d   = req_setpt_i;
    end
    if (launch) begin
      pend_v_d = 1'b0;
      word_d   = fmt_word;
      trim_d   = sel_trim;
      cs_hi_d  = sel_chan[1];
      if (!sel_trim) pol_d[sel_chan[1:0]] = fmt_neg;
    end
    if (pass_end) fb_d = '0;
    if (trap_hit) fb_d = '1;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pend_v_q    <= 1'b0;
      pend_trim_q <= 1'b0;
      pend_chan_q <= '0;
      pend_sp_q   <= '0;
      word_q      <= '0;
      trim_q      <= 1'b0;
      cs_hi_q     <= 1'b0;
      pol_q       <= '0;
      fb_q        <= '1;
      done_q      <= 1'b0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_trim_q <= pend_trim_d;
      pend_chan_q <= pend_chan_d;
      pend_sp_q   <= pend_sp_d;
      word_q      <= word_d;
      trim_q      <= trim_d;
      cs_hi_q     <= cs_hi_d;
      pol_q       <= pol_d;
      fb_q        <= fb_d;
      done_q      <= done_d;
    end
  end

  assign busy_o   = active || pend_v_q;
  assign done_o   = done_q;
  assign pol_o    = pol_q;
  assign fb_top_o = fb_q;
endmodule

// File: rtl/tsdac_seq_chk.sv
module tsdac_seq_chk
  import tsdac_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 sclk_o,
  input logic                 sdata_o,
  input logic [STRB_N-1:0]    cs_o,
  input logic [BYTE_BITS-1:0] fb_top_o
);
  AST_STRB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o)); // R5
  AST_SCLK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o == '0) |-> (!sclk_o && !sdata_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_o == '0 && !sclk_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_FB_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fb_top_o == 8'hFF)); // R8
  AST_FB_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_top_o == 8'hFF) || (fb_top_o == 8'h00)); // R8
  AST_FB_DROP_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fb_top_o[7]) |-> busy_o); // R8
endmodule

bind tsdac_seq tsdac_seq_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o),
  .cs_o     (cs_o),
  .fb_top_o (fb_top_o)
);

// File: tb/tsdac_seq_tb.sv
module tsdac_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_trim;
  logic [3:0]  req_chan;
  logic [15:0] req_sp;
  logic        busy, done, sclk, sdata;
  logic [3:0]  pol;
  logic [2:0]  cs;
  logic [7:0]  fb;

  always #2 clk = ~clk;

  tsdac_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_trim_i(req_trim),
    .req_chan_i(req_chan), .req_setpt_i(req_sp), .busy_o(busy), .done_o(done),
    .pol_o(pol), .sclk_o(sclk), .sdata_o(sdata), .cs_o(cs), .fb_top_o(fb)
  );

  typedef struct {
    logic [31:0] w;
    logic [11:0] csx;
    logic [3:0]  p;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] pol_model = 4'h0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // driver: builds the expected packet from the requirements, then pulses the request
  task automatic send(input bit trim, input logic [3:0] ch, input logic signed [15:0] sp, input bit taken);
    exp_t e;
    int m;
    logic [31:0] mv;
    logic [2:0] sel;
    if (taken) begin
      m = sp;
      if (m < 0) m = -m;
      if (m > 8191) m = 8191;                                  // R3
      mv = m;
      if (trim) begin
        e.w   = {4'h0, ch, sp[7:0], 16'h0000};                 // R6
        e.csx = {3'b100, 3'b100, 3'b100, 3'b100};
      end else begin
        e.w   = {ch[0], 2'b10, mv[12:8], mv[7:0], 8'h0F, 8'h00}; // R2
        sel   = ch[1] ? 3'b010 : 3'b001;                       // R5
        e.csx = {sel, sel, 3'b100, 3'b100};
        pol_model[ch[1:0]] = (sp < 0);                         // R4
      end
      e.p = pol_model;
      q.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b1; req_trim = trim; req_chan = ch; req_sp = sp;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after request", {31'd0, busy}, 32'd1);
  endtask

  task automatic drain();
    while (busy || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  logic [31:0] shreg;
  logic [2:0]  csr [4];
  int bits = 0;
  int run_len = 0;
  bit saw_zero = 1'b0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected packet", shreg, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(shreg == e.w, "R2/R3/R6 packet word", shreg, e.w);
          chk({csr[0], csr[1], csr[2], csr[3]} == e.csx, "R5 strobe per byte",
              {20'd0, csr[0], csr[1], csr[2], csr[3]}, {20'd0, e.csx});
          chk(pol == e.p, "R4 polarity", {28'd0, pol}, {28'd0, e.p});
          chk(bits == 32, "R7 bit count", bits, 32);
          chk(saw_zero && fb == 8'hFF, "R8 feedback 00 then FF", {23'd0, saw_zero, fb}, {23'd0, 1'b1, 8'hFF});
          chk(run_len == 96, "R9 pass length", run_len, 96);
          if (q.size() != 0) chk(busy == 1'b1, "R10 held request keeps busy", {31'd0, busy}, 32'd1);
        end
        bits = 0; run_len = 0; saw_zero = 1'b0; shreg = '0;
      end else begin
        if (busy) run_len++;
        if (busy && fb == 8'h00) saw_zero = 1'b1;
        if (sclk) begin
          if (bits == 0 && q.size() != 0)
            chk(pol == q[0].p, "R4 polarity before first clock", {28'd0, pol}, {28'd0, q[0].p});
          if (bits % 8 == 0 && bits < 32) csr[bits / 8] = cs;
          shreg = {shreg[30:0], sdata};
          bits++;
        end
      end
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", wd, 150000);
      summary();
    end
  end

  initial begin
    req_valid = 1'b0; req_trim = 1'b0; req_chan = '0; req_sp = '0;
    shreg = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done idle", {30'd0, busy, done}, 32'd0);
    chk(sclk == 0 && sdata == 0 && cs == 0, "R1 serial idle", {29'd0, cs} | {30'd0, sclk, sdata}, 32'd0);
    chk(fb == 8'hFF, "R1 feedback", {24'd0, fb}, 32'hFF);
    chk(pol == 4'h0, "R1 polarity", {28'd0, pol}, 32'd0);

    send(1'b0, 4'd0, 16'sh0123, 1'b1); drain();          // R2 plain
    send(1'b0, 4'd3, -16'sd100, 1'b1); drain();          // R4 negative, R5 second strobe
    send(1'b0, 4'd1, 16'sh7FFF, 1'b1); drain();          // R3 clamp high
    send(1'b0, 4'd2, -16'sd32768, 1'b1); drain();        // R3 most negative
    send(1'b0, 4'd3, 16'sd5, 1'b1); drain();             // R4 sign cleared
    send(1'b0, 4'd0, 16'sh2000, 1'b1); drain();          // R3 just above limit
    send(1'b0, 4'd1, 16'sh1FFF, 1'b1); drain();          // R3 at limit
    send(1'b1, 4'hA, 16'sh005C, 1'b1); drain();          // R6 trim, R4 unchanged
    send(1'b1, 4'h5, -16'sd1, 1'b1); drain();            // R6 trim with high bits set

    // R10: one held during a pass, a further one dropped
    send(1'b0, 4'd2, 16'sh0ABC, 1'b1);
    repeat (30) @(negedge clk);
    send(1'b0, 4'd1, -16'sd7, 1'b1);
    repeat (5) @(negedge clk);
    send(1'b0, 4'd0, -16'sd999, 1'b0);
    drain();
    chk(pol == pol_model, "R10 dropped request left polarity", {28'd0, pol}, {28'd0, pol_model});
    chk(busy == 1'b0, "R10 idle after held pass", {31'd0, busy}, 32'd0);
    repeat (200) @(negedge clk);
    chk(q.size() == 0, "R10 no stray packet", q.size(), 0);

    finished = 1'b1;
    summary();
  end
endmodule